// File: doc/BRIEF.md
# Type-Keyed Opcode Dispatch Table

This block sits in front of the execute stage of an interpreter-oriented core. Each cycle it takes a virtual arithmetic opcode together with the 8-bit type tags and the float/integer flags of both source operands. From these it decides combinationally where the operation goes. It can run natively on the integer ALU or on the floating-point ALU, each with a concrete ALU operation code. Otherwise it traps to a software handler whose entry address comes out of the table. The decision is ready before the instruction reaches execution.

The interpreter fills the table at start-up through a write port. Each entry is tagged by index and holds a valid bit, the full key, a route code, a concrete operation and a handler address. A clear pulse empties the whole table. A separate register holds the address of a fallback handler, which is used whenever no entry matches. Matching is fully associative. When more than one valid entry matches, the entry with the lowest index supplies the result.

Top module: `type_dispatch_table`

## Requirements
- R1: A lookup hits only when a valid entry matches all five key fields exactly: opcode, tag of operand A, tag of operand B, flag of operand A and flag of operand B. A key that differs in any one field, including a single flag, misses.
- R2: Route codes are 0 for the integer ALU, 1 for the floating-point ALU and 2 for a software handler. On a hit, `route` and `cop` show the route and concrete operation stored in the matching entry.
- R3: On a hit with route 2, `handler` shows the entry's stored address. On a hit with route 0 or 1, `handler` is zero.
- R4: On a miss, `hit` is 0, `route` is 2, `cop` is 0 and `handler` equals the fallback register.
- R5: When several valid entries match the same key, the lowest-index one determines all outputs.
- R6: A table write becomes visible at the outputs only after the next rising clock edge. The lookup path itself has no clock: outputs follow a change of key in the same cycle.
- R7: A write with `cfg_valid` low removes that entry. The next entry in index order that matches the key then takes over, or the lookup misses.
- R8: A `cfg_clear` pulse invalidates every entry at the next edge. It overrides a table write made in the same cycle, so that write leaves no valid entry.
- R9: Writing the fallback register with `dflt_we` changes the miss address from the next edge on.
- R10: After reset, all entries are invalid and the fallback register holds the parameter `DFLT_RST` (0x100 by default).
- R11: A route code of 3 written to an entry is stored as route 2 (software handler), and the entry keeps its handler address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_op | input | OP_W (5) | Virtual opcode being looked up |
| lk_tag_a | input | TAG_W (8) | Type tag of operand A |
| lk_tag_b | input | TAG_W (8) | Type tag of operand B |
| lk_fi_a | input | 1 | Operand A holds a float (1) or an integer (0) |
| lk_fi_b | input | 1 | Operand B holds a float (1) or an integer (0) |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | IDX_W (4) | Index of the entry written |
| cfg_valid | input | 1 | Valid bit written into the entry |
| cfg_op | input | OP_W (5) | Key opcode for the entry |
| cfg_tag_a | input | TAG_W (8) | Key tag A for the entry |
| cfg_tag_b | input | TAG_W (8) | Key tag B for the entry |
| cfg_fi_a | input | 1 | Key flag A for the entry |
| cfg_fi_b | input | 1 | Key flag B for the entry |
| cfg_route | input | 2 | Route code for the entry |
| cfg_cop | input | COP_W (6) | Concrete operation for the entry |
| cfg_handler | input | ADDR_W (32) | Handler entry address for the entry |
| cfg_clear | input | 1 | Invalidate all entries |
| dflt_we | input | 1 | Write the fallback handler register |
| dflt_addr | input | ADDR_W (32) | New fallback handler address |
| hit | output | 1 | A valid entry matched |
| route | output | 2 | Selected route |
| cop | output | COP_W (6) | Concrete operation |
| handler | output | ADDR_W (32) | Handler entry address |

## Verification
Because the lookup path has no register, a stale or corrupted entry is visible at the ports in the same cycle that its key is presented. A lost valid bit shows up as a miss to the fallback address. A wrong priority shows up as the concrete operation of a higher-index duplicate. A broken clear shows up as a hit on the first lookup after the pulse. Write timing is checked on both sides of the edge, so an entry that appears early or one cycle late is reported at once.

// File: rtl/dtab_pkg.sv
package dtab_pkg;
    localparam logic [1:0] RT_INT = 2'd0;
    localparam logic [1:0] RT_FP  = 2'd1;
    localparam logic [1:0] RT_SW  = 2'd2;

    // Reserved route code 3 is folded onto the software path.
    function automatic logic [1:0] legal_route(input logic [1:0] r);
        return (r == 2'd3) ? RT_SW : r;
    endfunction
endpackage

// File: rtl/dtab_store.sv
module dtab_store #(
    parameter int ENTRIES = 16,
    parameter int OP_W    = 5,
    parameter int TAG_W   = 8,
    parameter int COP_W   = 6,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [IDX_W-1:0]                  idx,
    input  logic                              w_valid,
    input  logic [OP_W-1:0]                   w_op,
    input  logic [TAG_W-1:0]                  w_tag_a,
    input  logic [TAG_W-1:0]                  w_tag_b,
    input  logic                              w_fi_a,
    input  logic                              w_fi_b,
    input  logic [1:0]                        w_route,
    input  logic [COP_W-1:0]                  w_cop,
    input  logic [ADDR_W-1:0]                 w_handler,
    input  logic                              clear,
    output logic [ENTRIES-1:0]                vld,
    output logic [ENTRIES-1:0][OP_W-1:0]      e_op,
    output logic [ENTRIES-1:0][TAG_W-1:0]     e_tag_a,
    output logic [ENTRIES-1:0][TAG_W-1:0]     e_tag_b,
    output logic [ENTRIES-1:0]                e_fi_a,
    output logic [ENTRIES-1:0]                e_fi_b,
    output logic [ENTRIES-1:0][1:0]           e_route,
    output logic [ENTRIES-1:0][COP_W-1:0]     e_cop,
    output logic [ENTRIES-1:0][ADDR_W-1:0]    e_handler
);
    import dtab_pkg::*;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][OP_W-1:0]   op;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag_a;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag_b;
        logic [ENTRIES-1:0]             fi_a;
        logic [ENTRIES-1:0]             fi_b;
        logic [ENTRIES-1:0][1:0]        route;
        logic [ENTRIES-1:0][COP_W-1:0]  cop;
        logic [ENTRIES-1:0][ADDR_W-1:0] handler;
    } tab_t;

    tab_t tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (clear) begin
            tab_d.vld = '0;
        end else if (we && (int'(idx) < ENTRIES)) begin
            tab_d.vld[idx]     = w_valid;
            tab_d.op[idx]      = w_op;
            tab_d.tag_a[idx]   = w_tag_a;
            tab_d.tag_b[idx]   = w_tag_b;
            tab_d.fi_a[idx]    = w_fi_a;
            tab_d.fi_b[idx]    = w_fi_b;
            tab_d.route[idx]   = legal_route(w_route);
            tab_d.cop[idx]     = w_cop;
            tab_d.handler[idx] = w_handler;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    assign vld       = tab_q.vld;
    assign e_op      = tab_q.op;
    assign e_tag_a   = tab_q.tag_a;
    assign e_tag_b   = tab_q.tag_b;
    assign e_fi_a    = tab_q.fi_a;
    assign e_fi_b    = tab_q.fi_b;
    assign e_route   = tab_q.route;
    assign e_cop     = tab_q.cop;
    assign e_handler = tab_q.handler;
endmodule

// File: rtl/dtab_match.sv
module dtab_match #(
    parameter int ENTRIES = 16,
    parameter int OP_W    = 5,
    parameter int TAG_W   = 8
) (
    input  logic [OP_W-1:0]               k_op,
    input  logic [TAG_W-1:0]              k_tag_a,
    input  logic [TAG_W-1:0]              k_tag_b,
    input  logic                          k_fi_a,
    input  logic                          k_fi_b,
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][OP_W-1:0]  e_op,
    input  logic [ENTRIES-1:0][TAG_W-1:0] e_tag_a,
    input  logic [ENTRIES-1:0][TAG_W-1:0] e_tag_b,
    input  logic [ENTRIES-1:0]            e_fi_a,
    input  logic [ENTRIES-1:0]            e_fi_b,
    output logic [ENTRIES-1:0]            match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g]
                        && (e_op[g]    == k_op)
                        && (e_tag_a[g] == k_tag_a)
                        && (e_tag_b[g] == k_tag_b)
                        && (e_fi_a[g]  == k_fi_a)
                        && (e_fi_b[g]  == k_fi_b);
    end
endmodule

// File: rtl/dtab_prio.sv
module dtab_prio #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic [ENTRIES-1:0] match,
    output logic               any,
    output logic [IDX_W-1:0]   sel
);
    // Scan from the top so the lowest matching index is the last to write.
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                any = 1'b1;
                sel = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/type_dispatch_table.sv
module type_dispatch_table #(
    parameter int          ENTRIES  = 16,
    parameter int          OP_W     = 5,
    parameter int          TAG_W    = 8,
    parameter int          COP_W    = 6,
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] DFLT_RST = 32'h0000_0100,
    localparam int         IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   lk_op,
    input  logic [TAG_W-1:0]  lk_tag_a,
    input  logic [TAG_W-1:0]  lk_tag_b,
    input  logic              lk_fi_a,
    input  logic              lk_fi_b,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic [OP_W-1:0]   cfg_op,
    input  logic [TAG_W-1:0]  cfg_tag_a,
    input  logic [TAG_W-1:0]  cfg_tag_b,
    input  logic              cfg_fi_a,
    input  logic              cfg_fi_b,
    input  logic [1:0]        cfg_route,
    input  logic [COP_W-1:0]  cfg_cop,
    input  logic [ADDR_W-1:0] cfg_handler,
    input  logic              cfg_clear,
    input  logic              dflt_we,
    input  logic [ADDR_W-1:0] dflt_addr,
    output logic              hit,
    output logic [1:0]        route,
    output logic [COP_W-1:0]  cop,
    output logic [ADDR_W-1:0] handler
);
    import dtab_pkg::*;

    logic [ENTRIES-1:0]             vld;
    logic [ENTRIES-1:0][OP_W-1:0]   e_op;
    logic [ENTRIES-1:0][TAG_W-1:0]  e_tag_a;
    logic [ENTRIES-1:0][TAG_W-1:0]  e_tag_b;
    logic [ENTRIES-1:0]             e_fi_a;
    logic [ENTRIES-1:0]             e_fi_b;
    logic [ENTRIES-1:0][1:0]        e_route;
    logic [ENTRIES-1:0][COP_W-1:0]  e_cop;
    logic [ENTRIES-1:0][ADDR_W-1:0] e_handler;
    logic [ENTRIES-1:0]             match;
    logic                           any;
    logic [IDX_W-1:0]               sel;
    logic [ADDR_W-1:0]              dflt_d, dflt_q;

    dtab_store #(
        .ENTRIES(ENTRIES), .OP_W(OP_W), .TAG_W(TAG_W),
        .COP_W(COP_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_we), .idx(cfg_idx), .w_valid(cfg_valid),
        .w_op(cfg_op), .w_tag_a(cfg_tag_a), .w_tag_b(cfg_tag_b),
        .w_fi_a(cfg_fi_a), .w_fi_b(cfg_fi_b), .w_route(cfg_route),
        .w_cop(cfg_cop), .w_handler(cfg_handler), .clear(cfg_clear),
        .vld(vld), .e_op(e_op), .e_tag_a(e_tag_a), .e_tag_b(e_tag_b),
        .e_fi_a(e_fi_a), .e_fi_b(e_fi_b), .e_route(e_route),
        .e_cop(e_cop), .e_handler(e_handler)
    );

    dtab_match #(.ENTRIES(ENTRIES), .OP_W(OP_W), .TAG_W(TAG_W)) match_i (
        .k_op(lk_op), .k_tag_a(lk_tag_a), .k_tag_b(lk_tag_b),
        .k_fi_a(lk_fi_a), .k_fi_b(lk_fi_b),
        .vld(vld), .e_op(e_op), .e_tag_a(e_tag_a), .e_tag_b(e_tag_b),
        .e_fi_a(e_fi_a), .e_fi_b(e_fi_b), .match(match)
    );

    dtab_prio #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) prio_i (
        .match(match), .any(any), .sel(sel)
    );

    // Fallback handler register.
    always_comb begin
        dflt_d = dflt_q;
        if (dflt_we) dflt_d = dflt_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dflt_q <= ADDR_W'(DFLT_RST);
        else        dflt_q <= dflt_d;
    end

    // Routing decision.
    always_comb begin
        hit     = 1'b0;
        route   = RT_SW;
        cop     = '0;
        handler = dflt_q;
        if (any) begin
            hit     = 1'b1;
            route   = e_route[sel];
            cop     = e_cop[sel];
            handler = (e_route[sel] == RT_SW) ? e_handler[sel] : '0;
        end
    end
endmodule

// File: rtl/dtab_checker.sv
module dtab_checker #(
    parameter int OP_W   = 5,
    parameter int TAG_W  = 8,
    parameter int COP_W  = 6,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   lk_op,
    input logic [TAG_W-1:0]  lk_tag_a,
    input logic [TAG_W-1:0]  lk_tag_b,
    input logic              lk_fi_a,
    input logic              lk_fi_b,
    input logic              cfg_we,
    input logic [IDX_W-1:0]  cfg_idx,
    input logic              cfg_valid,
    input logic [OP_W-1:0]   cfg_op,
    input logic [TAG_W-1:0]  cfg_tag_a,
    input logic [TAG_W-1:0]  cfg_tag_b,
    input logic              cfg_fi_a,
    input logic              cfg_fi_b,
    input logic [COP_W-1:0]  cfg_cop,
    input logic              cfg_clear,
    input logic              dflt_we,
    input logic [ADDR_W-1:0] dflt_addr,
    input logic              hit,
    input logic [1:0]        route,
    input logic [COP_W-1:0]  cop,
    input logic [ADDR_W-1:0] handler
);
    AST_ROUTE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        route != 2'd3); // R2

    AST_NATIVE_NO_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && route != 2'd2) |-> (handler == '0)); // R3

    AST_MISS_SW_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (route == 2'd2 && cop == '0)); // R4

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clear |=> !hit); // R8

    AST_DFLT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_we |=> (hit || handler == $past(dflt_addr))); // R9

    AST_SLOT0_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_clear && cfg_valid && cfg_idx == '0)
        |=> (!(lk_op == $past(cfg_op) && lk_tag_a == $past(cfg_tag_a)
               && lk_tag_b == $past(cfg_tag_b) && lk_fi_a == $past(cfg_fi_a)
               && lk_fi_b == $past(cfg_fi_b))
             || (hit && cop == $past(cfg_cop)))); // R6
endmodule

bind type_dispatch_table dtab_checker #(
    .OP_W(OP_W), .TAG_W(TAG_W), .COP_W(COP_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .lk_op(lk_op), .lk_tag_a(lk_tag_a), .lk_tag_b(lk_tag_b),
    .lk_fi_a(lk_fi_a), .lk_fi_b(lk_fi_b),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_op(cfg_op), .cfg_tag_a(cfg_tag_a), .cfg_tag_b(cfg_tag_b),
    .cfg_fi_a(cfg_fi_a), .cfg_fi_b(cfg_fi_b), .cfg_cop(cfg_cop),
    .cfg_clear(cfg_clear), .dflt_we(dflt_we), .dflt_addr(dflt_addr),
    .hit(hit), .route(route), .cop(cop), .handler(handler)
);

// File: tb/type_dispatch_table_tb_top.sv
`timescale 1ns/1ps
module type_dispatch_table_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  lk_op = '0;
    logic [7:0]  lk_tag_a = '0, lk_tag_b = '0;
    logic        lk_fi_a = 1'b0, lk_fi_b = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic        cfg_valid = 1'b0;
    logic [4:0]  cfg_op = '0;
    logic [7:0]  cfg_tag_a = '0, cfg_tag_b = '0;
    logic        cfg_fi_a = 1'b0, cfg_fi_b = 1'b0;
    logic [1:0]  cfg_route = '0;
    logic [5:0]  cfg_cop = '0;
    logic [31:0] cfg_handler = '0;
    logic        cfg_clear = 1'b0;
    logic        dflt_we = 1'b0;
    logic [31:0] dflt_addr = '0;
    logic        hit;
    logic [1:0]  route;
    logic [5:0]  cop;
    logic [31:0] handler;

    int n_vec = 0;
    int n_bad = 0;

    localparam logic [31:0] DFLT = 32'h0000_BAD0;

    always #4 clk = ~clk;

    type_dispatch_table dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_op(lk_op), .lk_tag_a(lk_tag_a), .lk_tag_b(lk_tag_b),
        .lk_fi_a(lk_fi_a), .lk_fi_b(lk_fi_b),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_op(cfg_op), .cfg_tag_a(cfg_tag_a), .cfg_tag_b(cfg_tag_b),
        .cfg_fi_a(cfg_fi_a), .cfg_fi_b(cfg_fi_b), .cfg_route(cfg_route),
        .cfg_cop(cfg_cop), .cfg_handler(cfg_handler), .cfg_clear(cfg_clear),
        .dflt_we(dflt_we), .dflt_addr(dflt_addr),
        .hit(hit), .route(route), .cop(cop), .handler(handler)
    );

    typedef struct packed {
        logic [4:0]  op;
        logic [7:0]  ta;
        logic [7:0]  tb;
        logic        fa;
        logic        fb;
        logic        ehit;
        logic [1:0]  eroute;
        logic [5:0]  ecop;
        logic [31:0] ehand;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{5'd1, 8'd3, 8'd3, 1'b0, 1'b0, 1'b1, 2'd0, 6'h01, 32'h0},       // R1 R2 int
        '{5'd1, 8'd4, 8'd4, 1'b1, 1'b1, 1'b1, 2'd1, 6'h11, 32'h0},       // R2 fp
        '{5'd1, 8'd3, 8'd4, 1'b0, 1'b1, 1'b1, 2'd2, 6'h00, 32'h1000},    // R3 mixed
        '{5'd1, 8'd4, 8'd3, 1'b1, 1'b0, 1'b0, 2'd2, 6'h00, DFLT},        // R4 swapped
        '{5'd2, 8'd3, 8'd3, 1'b0, 1'b0, 1'b1, 2'd0, 6'h02, 32'h0},       // R2 mul
        '{5'd2, 8'd7, 8'd7, 1'b0, 1'b0, 1'b1, 2'd2, 6'h00, 32'h2000},    // R3 composite
        '{5'd1, 8'd3, 8'd3, 1'b0, 1'b1, 1'b0, 2'd2, 6'h00, DFLT},        // R1 flag differs
        '{5'd9, 8'd5, 8'd6, 1'b1, 1'b0, 1'b1, 2'd2, 6'h00, 32'h3F00},    // R3 last slot
        '{5'd3, 8'd3, 8'd3, 1'b0, 1'b0, 1'b0, 2'd2, 6'h00, DFLT},        // R4 opcode miss
        '{5'd2, 8'd3, 8'd3, 1'b1, 1'b1, 1'b0, 2'd2, 6'h00, DFLT}         // R1 both flags
    };

    task automatic check(input string req, input logic eh, input logic [1:0] er,
                         input logic [5:0] ec, input logic [31:0] ea);
        n_vec++;
        if (hit !== eh || route !== er || cop !== ec || handler !== ea) begin
            n_bad++;
            $display("FAIL %s: got hit=%0b route=%0d cop=%h handler=%h, expected hit=%0b route=%0d cop=%h handler=%h",
                     req, hit, route, cop, handler, eh, er, ec, ea);
        end
    endtask

    task automatic key(input logic [4:0] op, input logic [7:0] ta, input logic [7:0] tb,
                       input logic fa, input logic fb);
        lk_op = op; lk_tag_a = ta; lk_tag_b = tb; lk_fi_a = fa; lk_fi_b = fb;
        #1;
    endtask

    // Drives one entry write after a falling edge; the caller decides when to clock.
    task automatic set_wr(input logic [3:0] idx, input logic v, input logic [4:0] op,
                          input logic [7:0] ta, input logic [7:0] tb, input logic fa,
                          input logic fb, input logic [1:0] rt, input logic [5:0] c,
                          input logic [31:0] h);
        cfg_we = 1'b1; cfg_idx = idx; cfg_valid = v; cfg_op = op;
        cfg_tag_a = ta; cfg_tag_b = tb; cfg_fi_a = fa; cfg_fi_b = fb;
        cfg_route = rt; cfg_cop = c; cfg_handler = h;
    endtask

    task automatic clock_in();
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; cfg_clear = 1'b0; dflt_we = 1'b0;
        #1;
    endtask

    task automatic write(input logic [3:0] idx, input logic v, input logic [4:0] op,
                         input logic [7:0] ta, input logic [7:0] tb, input logic fa,
                         input logic fb, input logic [1:0] rt, input logic [5:0] c,
                         input logic [31:0] h);
        set_wr(idx, v, op, ta, tb, fa, fb, rt, c, h);
        clock_in();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: empty table, reset fallback address
        key(5'd1, 8'd3, 8'd3, 1'b0, 1'b0);
        check("R10 reset state", 1'b0, 2'd2, 6'h00, 32'h100);

        // R9: fallback write not visible before the edge, visible after
        @(negedge clk);
        dflt_we = 1'b1; dflt_addr = DFLT;
        #1;
        check("R9 fallback before edge", 1'b0, 2'd2, 6'h00, 32'h100);
        clock_in();
        check("R9 fallback after edge", 1'b0, 2'd2, 6'h00, DFLT);

        // R6: entry write not visible in the same cycle, visible after the edge
        set_wr(4'd0, 1'b1, 5'd1, 8'd3, 8'd3, 1'b0, 1'b0, 2'd0, 6'h01, 32'hDEAD);
        #1;
        check("R6 write before edge", 1'b0, 2'd2, 6'h00, DFLT);
        clock_in();
        check("R6 write after edge", 1'b1, 2'd0, 6'h01, 32'h0);

        write(4'd1, 1'b1, 5'd1, 8'd4, 8'd4, 1'b1, 1'b1, 2'd1, 6'h11, 32'h0);
        write(4'd2, 1'b1, 5'd1, 8'd3, 8'd4, 1'b0, 1'b1, 2'd2, 6'h00, 32'h1000);
        write(4'd3, 1'b1, 5'd2, 8'd3, 8'd3, 1'b0, 1'b0, 2'd0, 6'h02, 32'h0);
        write(4'd4, 1'b1, 5'd2, 8'd7, 8'd7, 1'b0, 1'b0, 2'd2, 6'h00, 32'h2000);
        write(4'd15, 1'b1, 5'd9, 8'd5, 8'd6, 1'b1, 1'b0, 2'd2, 6'h00, 32'h3F00);

        // Vector walk: R1 R2 R3 R4, key changes with no clock (R6 lookup path)
        for (int i = 0; i < NV; i++) begin
            key(VECS[i].op, VECS[i].ta, VECS[i].tb, VECS[i].fa, VECS[i].fb);
            check($sformatf("R1/R2/R3/R4 vector %0d", i), VECS[i].ehit,
                  VECS[i].eroute, VECS[i].ecop, VECS[i].ehand);
        end

        // R11: route code 3 is stored as software handler
        write(4'd5, 1'b1, 5'd4, 8'd1, 8'd1, 1'b0, 1'b0, 2'd3, 6'h07, 32'h4400);
        key(5'd4, 8'd1, 8'd1, 1'b0, 1'b0);
        check("R11 route 3 folded", 1'b1, 2'd2, 6'h07, 32'h4400);

        // R5: duplicate key at a higher index loses
        write(4'd8, 1'b1, 5'd1, 8'd3, 8'd3, 1'b0, 1'b0, 2'd2, 6'h3A, 32'h5500);
        key(5'd1, 8'd3, 8'd3, 1'b0, 1'b0);
        check("R5 lowest index wins", 1'b1, 2'd0, 6'h01, 32'h0);

        // R7: invalidating slot 0 hands the key to slot 8
        write(4'd0, 1'b0, 5'd1, 8'd3, 8'd3, 1'b0, 1'b0, 2'd0, 6'h01, 32'h0);
        check("R7 invalidate exposes next", 1'b1, 2'd2, 6'h3A, 32'h5500);
        write(4'd8, 1'b0, 5'd1, 8'd3, 8'd3, 1'b0, 1'b0, 2'd2, 6'h3A, 32'h5500);
        check("R7 invalidate last match", 1'b0, 2'd2, 6'h00, DFLT);

        // R8: clear with a simultaneous write leaves nothing valid
        set_wr(4'd9, 1'b1, 5'd6, 8'd2, 8'd2, 1'b0, 1'b0, 2'd0, 6'h06, 32'h0);
        cfg_clear = 1'b1;
        clock_in();
        key(5'd6, 8'd2, 8'd2, 1'b0, 1'b0);
        check("R8 clear beats write", 1'b0, 2'd2, 6'h00, DFLT);
        key(5'd1, 8'd4, 8'd4, 1'b1, 1'b1);
        check("R8 clear empties fp entry", 1'b0, 2'd2, 6'h00, DFLT);
        key(5'd9, 8'd5, 8'd6, 1'b1, 1'b0);
        check("R8 clear empties last slot", 1'b0, 2'd2, 6'h00, DFLT);

        // R10: reset again restores fallback address
        rst_n = 1'b0;
        #1;
        rst_n = 1'b1;
        #1;
        check("R10 reset restores fallback", 1'b0, 2'd2, 6'h00, 32'h100);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule